// File: doc/BRIEF.md
# Queue-Port Messaging Unit

This block is a target-side messaging unit between a host and an I/O processor. The host reaches it over a simple 32-bit register bus. Each of its two queue ports has a single address, and a read of that address acts on a different FIFO than a write does. The inbound port hands out free request handles on a read and accepts posted requests on a write. The outbound port hands out completions on a read and accepts returned handles on a write. The local side is the processor. It pops posted requests, pushes completions and answers messages through plain strobes.

Two handle encodings travel through the queues. A handle with bit 31 clear is an offset into the processor's memory window. A handle with bit 31 set names a request in host memory: its low 31 bits are that request's bus address divided by 32. The unit checks every handle it receives and drops any handle that breaks its encoding. Commands that do not go through the queues are written to an inbound message register. Such a command counts as finished when the processor writes the same value back into outbound message 0. Each direction has a status register and a mask register, and one interrupt line per side is driven from them.

Top module: `qport_msg_unit`

## Requirements
- R1: After reset, both status registers read 0 and both interrupts are low. The free pool holds DEPTH handles. Successive reads of the inbound port (offset 0x40) return FREE_BASE, FREE_BASE+FREE_STEP and so on, in that order.
- R2: A host write to the inbound port posts the handle to the processor. Posted handles come out of lclPostHandle in write order while lclPostValid is high. Each lclPostPop removes one.
- R3: A read of an empty queue port (0x40 or 0x44) returns 0xFFFFFFFF and changes no state. Read data appears on busRdata, with busRvalid high, in the cycle after busRdEn.
- R4: A post to a full queue is dropped and sets the sticky inbound status bit 4. This covers a host post to the inbound port and a handle returned to the free pool.
- R5: If a posted handle has bit 31 set, lclPostIsHost is 1 and lclPostHostAddr equals {handle[30:0], 5'b0}. If a posted handle has bit 31 clear and any of bits 4..0 set, it is dropped and sets the sticky inbound status bit 5.
- R6: A host write to the outbound port (0x44) returns the handle to the tail of the free pool. A returned handle with bit 31 set, or with any of bits 4..0 set, is dropped and sets inbound status bit 5.
- R7: lclCmplPush appends lclCmplData to the completion FIFO. A host read of 0x44 pops completions in push order. Outbound status bit 3 is 1 exactly while that FIFO is non-empty. A push to a full completion FIFO is dropped and sets the sticky outbound status bit 4.
- R8: Host writes to 0x10 and 0x14 load inbound messages 0 and 1, which show on lclInMsg0 and lclInMsg1. These writes set inbound status bits 0 and 1. A local write to outbound message 0 or 1 (read at 0x18 and 0x1C) sets outbound status bit 0 or 1. Outbound status bit 2 is also set when the value written to outbound message 0 equals inbound message 0.
- R9: A host write to the doorbell (0x20) ORs the data into it, and lclDbClr clears the selected bits. Inbound status bit 2 is 1 exactly while the doorbell is non-zero.
- R10: Writing 1 to a bit of inbound status (0x24) or outbound status (0x30) clears that bit if it is sticky. A bit that shows a live condition stays set while the condition holds.
- R11: lclIrq is the OR over the inbound status bits whose bits in the inbound mask (0x28) are 0. hostIrq is the same function of outbound status and the outbound mask (0x34). Both masks reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe (reads of a queue port pop it) |
| busRdata | output | 32 | Read data, valid one cycle after busRdEn |
| busRvalid | output | 1 | Read data valid |
| hostIrq | output | 1 | Interrupt to the host |
| lclIrq | output | 1 | Interrupt to the processor |
| lclPostValid | output | 1 | Posted request available |
| lclPostHandle | output | 32 | Oldest posted handle |
| lclPostIsHost | output | 1 | Oldest posted handle names host memory |
| lclPostHostAddr | output | 36 | Decoded host bus address of that handle |
| lclPostPop | input | 1 | Remove the oldest posted handle |
| lclCmplPush | input | 1 | Push a completion |
| lclCmplData | input | 32 | Completion handle or context value |
| lclInMsg0 | output | 32 | Inbound message 0 |
| lclInMsg1 | output | 32 | Inbound message 1 |
| lclDoorbell | output | 32 | Inbound doorbell bits |
| lclDbClr | input | 32 | Doorbell bits to clear |
| lclInStsClr | input | 6 | Inbound sticky status bits to clear |
| lclOutMsgWr | input | 1 | Write an outbound message |
| lclOutMsgSel | input | 1 | 0 selects outbound message 0, 1 selects message 1 |
| lclOutMsgData | input | 32 | Outbound message value |

## Verification
Directed sequences cover the port corners:
- draining the preloaded pool and reading one past the end, which separates order errors from empty handling;
- filling each FIFO until one post is dropped, which exposes off-by-one depth limits;
- handles that break the encoding rules, which show whether the check drops them or lets them through;
- echoed and non-echoed messages, which separate the echo-match bit from the plain message-event bits.

After these, a seeded random mix of posts, local pops, completion pushes and host reads runs against queue models in the bench. It reveals ordering errors, lost entries and corruption that appear only when pushes and pops interleave. Mask and W1C writes are applied both while the live conditions hold and after they have gone. This tells apart the sticky and live status bits and shows that the interrupt gating is correct.

// File: rtl/qpm_pkg.sv
package qpm_pkg;

  localparam int STS_W = 6;

  localparam logic [7:0] OFF_IMSG0   = 8'h10;
  localparam logic [7:0] OFF_IMSG1   = 8'h14;
  localparam logic [7:0] OFF_OMSG0   = 8'h18;
  localparam logic [7:0] OFF_OMSG1   = 8'h1C;
  localparam logic [7:0] OFF_DB      = 8'h20;
  localparam logic [7:0] OFF_INSTS   = 8'h24;
  localparam logic [7:0] OFF_INMASK  = 8'h28;
  localparam logic [7:0] OFF_OUTSTS  = 8'h30;
  localparam logic [7:0] OFF_OUTMASK = 8'h34;
  localparam logic [7:0] OFF_INPORT  = 8'h40;
  localparam logic [7:0] OFF_OUTPORT = 8'h44;

  localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;

  typedef enum logic [3:0] {
    RD_NONE, RD_IMSG0, RD_IMSG1, RD_OMSG0, RD_OMSG1, RD_DB,
    RD_INSTS, RD_INMASK, RD_OUTSTS, RD_OUTMASK, RD_INPORT, RD_OUTPORT
  } rdSel_e;

  typedef struct packed {
    logic   popFree;
    logic   pushPost;
    logic   popCmpl;
    logic   pushFree;
    logic   wrIMsg0;
    logic   wrIMsg1;
    logic   wrDb;
    logic   clrInSts;
    logic   clrOutSts;
    logic   wrInMask;
    logic   wrOutMask;
    logic   rdEn;
    rdSel_e rdSel;
  } strobes_t;

endpackage

// File: rtl/qpm_fifo.sv
module qpm_fifo #(
  parameter int          W       = 32,
  parameter int          DEPTH   = 16,
  parameter bit          PRELOAD = 1'b0,
  parameter logic [W-1:0] BASE   = '0,
  parameter logic [W-1:0] STEP   = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         dropped
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] rdPtr, wrPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_MAX);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign dropped = push && full;
  assign head    = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= PRELOAD ? (BASE + STEP * W'(i)) : '0;
      rdPtr <= '0;
      wrPtr <= '0;
      count <= PRELOAD ? CNT_MAX : '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R4: a push into a full FIFO must not change its fill level
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> full);
  // R3: popping an empty FIFO leaves it empty
  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push) |=> empty);
  // R2: fill level stays within the storage
  a_r2_count_range: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_MAX);

endmodule

// File: rtl/qpm_ctrl.sv
module qpm_ctrl
  import qpm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          stb
);

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    if (busWrEn) begin
      case (busAddr)
        ADDR_W'(OFF_IMSG0):   stb.wrIMsg0   = 1'b1;
        ADDR_W'(OFF_IMSG1):   stb.wrIMsg1   = 1'b1;
        ADDR_W'(OFF_DB):      stb.wrDb      = 1'b1;
        ADDR_W'(OFF_INSTS):   stb.clrInSts  = 1'b1;
        ADDR_W'(OFF_INMASK):  stb.wrInMask  = 1'b1;
        ADDR_W'(OFF_OUTSTS):  stb.clrOutSts = 1'b1;
        ADDR_W'(OFF_OUTMASK): stb.wrOutMask = 1'b1;
        ADDR_W'(OFF_INPORT):  stb.pushPost  = 1'b1;
        ADDR_W'(OFF_OUTPORT): stb.pushFree  = 1'b1;
        default: ;
      endcase
    end
    if (busRdEn) begin
      stb.rdEn = 1'b1;
      case (busAddr)
        ADDR_W'(OFF_IMSG0):   stb.rdSel = RD_IMSG0;
        ADDR_W'(OFF_IMSG1):   stb.rdSel = RD_IMSG1;
        ADDR_W'(OFF_OMSG0):   stb.rdSel = RD_OMSG0;
        ADDR_W'(OFF_OMSG1):   stb.rdSel = RD_OMSG1;
        ADDR_W'(OFF_DB):      stb.rdSel = RD_DB;
        ADDR_W'(OFF_INSTS):   stb.rdSel = RD_INSTS;
        ADDR_W'(OFF_INMASK):  stb.rdSel = RD_INMASK;
        ADDR_W'(OFF_OUTSTS):  stb.rdSel = RD_OUTSTS;
        ADDR_W'(OFF_OUTMASK): stb.rdSel = RD_OUTMASK;
        ADDR_W'(OFF_INPORT):  begin stb.rdSel = RD_INPORT;  stb.popFree = 1'b1; end
        ADDR_W'(OFF_OUTPORT): begin stb.rdSel = RD_OUTPORT; stb.popCmpl = 1'b1; end
        default: ;
      endcase
    end
  end

  // R2/R6: a single bus write never drives two register actions
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.pushPost, stb.pushFree, stb.wrIMsg0, stb.wrIMsg1, stb.wrDb,
              stb.clrInSts, stb.clrOutSts, stb.wrInMask, stb.wrOutMask}));
  // R3: queue pops only come from a read
  a_r3_pop_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (stb.popFree || stb.popCmpl) |-> busRdEn);

endmodule

// File: rtl/qpm_datapath.sv
module qpm_datapath
  import qpm_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter logic [31:0] FREE_BASE = 32'h0000_1000,
  parameter logic [31:0] FREE_STEP = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic             busRvalid,
  output logic             hostIrq,
  output logic             lclIrq,
  output logic             lclPostValid,
  output logic [31:0]      lclPostHandle,
  output logic             lclPostIsHost,
  output logic [35:0]      lclPostHostAddr,
  input  logic             lclPostPop,
  input  logic             lclCmplPush,
  input  logic [31:0]      lclCmplData,
  output logic [31:0]      lclInMsg0,
  output logic [31:0]      lclInMsg1,
  output logic [31:0]      lclDoorbell,
  input  logic [31:0]      lclDbClr,
  input  logic [STS_W-1:0] lclInStsClr,
  input  logic             lclOutMsgWr,
  input  logic             lclOutMsgSel,
  input  logic [31:0]      lclOutMsgData
);

  logic [31:0] freeHead, postHead, cmplHead;
  logic        freeEmpty, freeFull, freeDrop;
  logic        postEmpty, postFull, postDrop;
  logic        cmplEmpty, cmplFull, cmplDrop;
  logic        postOk, freeOk, pushPost, pushFree, badHandle;

  logic [31:0]      iMsg0, iMsg1, oMsg0, oMsg1, doorbell;
  logic [STS_W-1:0] inSticky, outSticky, inMask, outMask;
  logic [STS_W-1:0] inSts, outSts, inSet, outSet, inClr, outClr;
  logic             echoHit;

  // Handle encoding check
  assign postOk    = busWdata[31] || (busWdata[4:0] == 5'd0);
  assign freeOk    = !busWdata[31] && (busWdata[4:0] == 5'd0);
  assign pushPost  = stb.pushPost && postOk;
  assign pushFree  = stb.pushFree && freeOk;
  assign badHandle = (stb.pushPost && !postOk) || (stb.pushFree && !freeOk);

  qpm_fifo #(.W(32), .DEPTH(DEPTH), .PRELOAD(1'b1), .BASE(FREE_BASE), .STEP(FREE_STEP))
    uFree (.clk(clk), .rstN(rstN), .push(pushFree), .pushData(busWdata), .pop(stb.popFree),
           .head(freeHead), .empty(freeEmpty), .full(freeFull), .dropped(freeDrop));

  qpm_fifo #(.W(32), .DEPTH(DEPTH), .PRELOAD(1'b0), .BASE(32'd0), .STEP(32'd0))
    uPost (.clk(clk), .rstN(rstN), .push(pushPost), .pushData(busWdata), .pop(lclPostPop),
           .head(postHead), .empty(postEmpty), .full(postFull), .dropped(postDrop));

  qpm_fifo #(.W(32), .DEPTH(DEPTH), .PRELOAD(1'b0), .BASE(32'd0), .STEP(32'd0))
    uCmpl (.clk(clk), .rstN(rstN), .push(lclCmplPush), .pushData(lclCmplData), .pop(stb.popCmpl),
           .head(cmplHead), .empty(cmplEmpty), .full(cmplFull), .dropped(cmplDrop));

  // Status composition: sticky events ORed with live conditions
  assign inSts  = {inSticky[5:4], !postEmpty, (doorbell != '0), inSticky[1:0]};
  assign outSts = {1'b0, outSticky[4], !cmplEmpty, outSticky[2:0]};

  assign echoHit = lclOutMsgWr && !lclOutMsgSel && (lclOutMsgData == iMsg0);

  assign inSet  = {badHandle, (postDrop || freeDrop), 2'b00, stb.wrIMsg1, stb.wrIMsg0};
  assign outSet = {1'b0, cmplDrop, 1'b0, echoHit,
                   lclOutMsgWr && lclOutMsgSel, lclOutMsgWr && !lclOutMsgSel};
  assign inClr  = (stb.clrInSts  ? busWdata[STS_W-1:0] : '0) | lclInStsClr;
  assign outClr =  stb.clrOutSts ? busWdata[STS_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iMsg0     <= '0;
      iMsg1     <= '0;
      oMsg0     <= '0;
      oMsg1     <= '0;
      doorbell  <= '0;
      inSticky  <= '0;
      outSticky <= '0;
      inMask    <= '0;
      outMask   <= '0;
    end else begin
      if (stb.wrIMsg0) iMsg0 <= busWdata;
      if (stb.wrIMsg1) iMsg1 <= busWdata;
      if (lclOutMsgWr && !lclOutMsgSel) oMsg0 <= lclOutMsgData;
      if (lclOutMsgWr &&  lclOutMsgSel) oMsg1 <= lclOutMsgData;
      doorbell  <= (doorbell | (stb.wrDb ? busWdata : '0)) & ~lclDbClr;
      inSticky  <= (inSticky  & ~inClr)  | inSet;
      outSticky <= (outSticky & ~outClr) | outSet;
      if (stb.wrInMask)  inMask  <= busWdata[STS_W-1:0];
      if (stb.wrOutMask) outMask <= busWdata[STS_W-1:0];
    end
  end

  // Registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= stb.rdEn;
      if (stb.rdEn) begin
        case (stb.rdSel)
          RD_IMSG0:   busRdata <= iMsg0;
          RD_IMSG1:   busRdata <= iMsg1;
          RD_OMSG0:   busRdata <= oMsg0;
          RD_OMSG1:   busRdata <= oMsg1;
          RD_DB:      busRdata <= doorbell;
          RD_INSTS:   busRdata <= 32'(inSts);
          RD_INMASK:  busRdata <= 32'(inMask);
          RD_OUTSTS:  busRdata <= 32'(outSts);
          RD_OUTMASK: busRdata <= 32'(outMask);
          RD_INPORT:  busRdata <= freeEmpty ? EMPTY_WORD : freeHead;
          RD_OUTPORT: busRdata <= cmplEmpty ? EMPTY_WORD : cmplHead;
          default:    busRdata <= '0;
        endcase
      end
    end
  end

  assign hostIrq = |(outSts & ~outMask);
  assign lclIrq  = |(inSts & ~inMask);

  assign lclPostValid    = !postEmpty;
  assign lclPostHandle   = postHead;
  assign lclPostIsHost   = postHead[31];
  assign lclPostHostAddr = {postHead[30:0], 5'b00000};
  assign lclInMsg0       = iMsg0;
  assign lclInMsg1       = iMsg1;
  assign lclDoorbell     = doorbell;

  // R7: a pending completion with its mask bit open raises the host line
  a_r7_cmpl_irq: assert property (@(posedge clk) disable iff (!rstN)
    (!cmplEmpty && !outMask[3]) |-> hostIrq);
  // R4: a dropped post leaves the overflow flag set
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (postDrop || freeDrop) |=> inSts[4]);
  // R5: a badly encoded handle leaves the error flag set
  a_r5_bad_handle: assert property (@(posedge clk) disable iff (!rstN)
    badHandle |=> inSts[5]);
  // R8: echoing inbound message 0 marks the command complete
  a_r8_echo: assert property (@(posedge clk) disable iff (!rstN)
    echoHit |=> outSts[2]);
  // R10: a live condition survives a W1C write
  a_r10_live_post: assert property (@(posedge clk) disable iff (!rstN)
    (!postEmpty && !lclPostPop) |=> inSts[3]);

endmodule

// File: rtl/qport_msg_unit.sv
module qport_msg_unit
  import qpm_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DEPTH     = 16,
  parameter logic [31:0] FREE_BASE = 32'h0000_1000,
  parameter logic [31:0] FREE_STEP = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWdata,
  input  logic              busRdEn,
  output logic [31:0]       busRdata,
  output logic              busRvalid,
  output logic              hostIrq,
  output logic              lclIrq,
  output logic              lclPostValid,
  output logic [31:0]       lclPostHandle,
  output logic              lclPostIsHost,
  output logic [35:0]       lclPostHostAddr,
  input  logic              lclPostPop,
  input  logic              lclCmplPush,
  input  logic [31:0]       lclCmplData,
  output logic [31:0]       lclInMsg0,
  output logic [31:0]       lclInMsg1,
  output logic [31:0]       lclDoorbell,
  input  logic [31:0]       lclDbClr,
  input  logic [5:0]        lclInStsClr,
  input  logic              lclOutMsgWr,
  input  logic              lclOutMsgSel,
  input  logic [31:0]       lclOutMsgData
);

  strobes_t stb;

  qpm_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .stb(stb));

  qpm_datapath #(.DEPTH(DEPTH), .FREE_BASE(FREE_BASE), .FREE_STEP(FREE_STEP)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid), .hostIrq(hostIrq), .lclIrq(lclIrq),
    .lclPostValid(lclPostValid), .lclPostHandle(lclPostHandle),
    .lclPostIsHost(lclPostIsHost), .lclPostHostAddr(lclPostHostAddr),
    .lclPostPop(lclPostPop), .lclCmplPush(lclCmplPush), .lclCmplData(lclCmplData),
    .lclInMsg0(lclInMsg0), .lclInMsg1(lclInMsg1), .lclDoorbell(lclDoorbell),
    .lclDbClr(lclDbClr), .lclInStsClr(lclInStsClr), .lclOutMsgWr(lclOutMsgWr),
    .lclOutMsgSel(lclOutMsgSel), .lclOutMsgData(lclOutMsgData));

endmodule

// File: tb/tb_qport_msg_unit.sv
module tb_qport_msg_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] STEP = 32'h0000_0100;
  localparam logic [7:0] A_IM0 = 8'h10, A_IM1 = 8'h14, A_OM0 = 8'h18, A_OM1 = 8'h1C;
  localparam logic [7:0] A_DB = 8'h20, A_IS = 8'h24, A_IMK = 8'h28, A_OS = 8'h30;
  localparam logic [7:0] A_OMK = 8'h34, A_INP = 8'h40, A_OUTP = 8'h44;

  logic clk = 0, rstN = 0;
  logic [7:0] busAddr = '0;
  logic busWrEn = 0, busRdEn = 0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busRvalid, hostIrq, lclIrq, lclPostValid, lclPostIsHost;
  logic [31:0] lclPostHandle, lclInMsg0, lclInMsg1, lclDoorbell;
  logic [35:0] lclPostHostAddr;
  logic lclPostPop = 0, lclCmplPush = 0, lclOutMsgWr = 0, lclOutMsgSel = 0;
  logic [31:0] lclCmplData = '0, lclDbClr = '0, lclOutMsgData = '0;
  logic [5:0] lclInStsClr = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rd;
  logic [31:0] mPost[$];
  logic [31:0] mCmpl[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qport_msg_unit dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] hostHandle(input logic [35:0] addr);
    return 32'h8000_0000 | 32'(addr >> 5);
  endfunction

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrEn = 1;
    @(negedge clk); busWrEn = 0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1;
    @(negedge clk); busRdEn = 0; d = busRdata;
    chk("R3 rvalid", 64'(busRvalid), 64'd1);
  endtask

  task automatic lclPop();
    @(negedge clk); lclPostPop = 1;
    @(negedge clk); lclPostPop = 0;
  endtask

  task automatic lclPush(input logic [31:0] d);
    @(negedge clk); lclCmplPush = 1; lclCmplData = d;
    @(negedge clk); lclCmplPush = 0;
  endtask

  task automatic lclMsg(input logic sel, input logic [31:0] d);
    @(negedge clk); lclOutMsgWr = 1; lclOutMsgSel = sel; lclOutMsgData = d;
    @(negedge clk); lclOutMsgWr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] h;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    busRead(A_IS, rd);  chk("R1 inSts", 64'(rd), 64'd0);
    busRead(A_OS, rd);  chk("R1 outSts", 64'(rd), 64'd0);
    chk("R1 irqs", 64'({hostIrq, lclIrq, lclPostValid}), 64'd0);
    for (int k = 0; k < DEPTH; k++) begin
      busRead(A_INP, rd); chk("R1 free order", 64'(rd), 64'(BASE + STEP * 32'(k)));
    end
    busRead(A_INP, rd);  chk("R3 empty inport", 64'(rd), 64'hFFFF_FFFF);
    busRead(A_OUTP, rd); chk("R3 empty outport", 64'(rd), 64'hFFFF_FFFF);

    // R6 return to free pool
    busWrite(A_OUTP, 32'h1000);
    busWrite(A_OUTP, 32'h1300);
    busWrite(A_OUTP, 32'h8000_0001);
    busRead(A_INP, rd); chk("R6 free return 0", 64'(rd), 64'h1000);
    busRead(A_INP, rd); chk("R6 free return 1", 64'(rd), 64'h1300);
    busRead(A_INP, rd); chk("R6 host handle dropped", 64'(rd), 64'hFFFF_FFFF);
    busRead(A_IS, rd);  chk("R6 bad flag", 64'(rd[5]), 64'd1);
    busWrite(A_IS, 32'h20);
    busRead(A_IS, rd);  chk("R10 w1c bit5", 64'(rd[5]), 64'd0);

    // R2 / R5 posting and encoding
    busWrite(A_INP, 32'h1300);
    busWrite(A_INP, hostHandle(36'h1_2345_6780));
    busWrite(A_INP, 32'h0000_1304);
    chk("R2 post valid", 64'(lclPostValid), 64'd1);
    chk("R2 post head", 64'(lclPostHandle), 64'h1300);
    chk("R5 proc flag", 64'(lclPostIsHost), 64'd0);
    busRead(A_IS, rd);  chk("R10 live bit3 and R5 bad", 64'(rd[5:3]), 64'b101);
    chk("R11 lclIrq", 64'(lclIrq), 64'd1);
    lclPop();
    chk("R5 host flag", 64'(lclPostIsHost), 64'd1);
    chk("R5 host addr", 64'(lclPostHostAddr), 64'h1_2345_6780);
    busWrite(A_IS, 32'h3F);
    busRead(A_IS, rd);  chk("R10 live survives w1c", 64'(rd), 64'h08);
    busWrite(A_IMK, 32'h08);
    chk("R11 masked lclIrq", 64'(lclIrq), 64'd0);
    busWrite(A_IMK, 32'h00);
    lclPop();
    chk("R5 bad handle not posted", 64'(lclPostValid), 64'd0);
    busRead(A_IS, rd);  chk("R10 live clears", 64'(rd), 64'd0);

    // R4 overflow
    for (int k = 0; k <= DEPTH; k++) busWrite(A_INP, 32'h2000 + 32'(k) * 32'h20);
    busRead(A_IS, rd);  chk("R4 ovf flag", 64'(rd[4]), 64'd1);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R4 kept entries", 64'(lclPostHandle), 64'(32'h2000 + 32'(k) * 32'h20));
      lclPop();
    end
    chk("R4 dropped entry absent", 64'(lclPostValid), 64'd0);
    lclInStsClr = 6'h10; @(negedge clk); lclInStsClr = '0;
    busRead(A_IS, rd);  chk("R10 local clear", 64'(rd[4]), 64'd0);

    // R7 completions
    lclPush(32'hC0DE_0001); lclPush(32'h8000_1234); lclPush(32'h0000_1100);
    busRead(A_OS, rd);  chk("R7 outSts bit3", 64'(rd[3]), 64'd1);
    chk("R11 hostIrq", 64'(hostIrq), 64'd1);
    busWrite(A_OMK, 32'h08);
    chk("R11 masked hostIrq", 64'(hostIrq), 64'd0);
    busWrite(A_OMK, 32'h00);
    busRead(A_OUTP, rd); chk("R7 order 0", 64'(rd), 64'hC0DE_0001);
    busRead(A_OUTP, rd); chk("R7 order 1", 64'(rd), 64'h8000_1234);
    busRead(A_OUTP, rd); chk("R7 order 2", 64'(rd), 64'h0000_1100);
    busRead(A_OS, rd);  chk("R7 bit3 clears", 64'(rd[3]), 64'd0);
    for (int k = 0; k <= DEPTH; k++) lclPush(32'h7000 + 32'(k));
    busRead(A_OS, rd);  chk("R7 cmpl overflow", 64'(rd[4:3]), 64'b11);
    for (int k = 0; k < DEPTH; k++) begin
      busRead(A_OUTP, rd); chk("R7 drain", 64'(rd), 64'(32'h7000 + 32'(k)));
    end
    busWrite(A_OS, 32'h3F);
    busRead(A_OS, rd);  chk("R10 out w1c", 64'(rd), 64'd0);

    // R8 messages
    busWrite(A_IM0, 32'hA5A5_0001);
    busWrite(A_IM1, 32'h0000_BEEF);
    chk("R8 lclInMsg0", 64'(lclInMsg0), 64'hA5A5_0001);
    chk("R8 lclInMsg1", 64'(lclInMsg1), 64'h0000_BEEF);
    busRead(A_IS, rd);  chk("R8 in msg bits", 64'(rd[1:0]), 64'b11);
    lclMsg(1'b0, 32'hA5A5_0001);
    busRead(A_OS, rd);  chk("R8 echo bits", 64'(rd[2:0]), 64'b101);
    busRead(A_OM0, rd); chk("R8 omsg0", 64'(rd), 64'hA5A5_0001);
    busWrite(A_OS, 32'h07);
    lclMsg(1'b1, 32'h1234_5678);
    lclMsg(1'b0, 32'h0000_0002);
    busRead(A_OS, rd);  chk("R8 no echo", 64'(rd[2:0]), 64'b011);
    busRead(A_OM1, rd); chk("R8 omsg1", 64'(rd), 64'h1234_5678);
    busWrite(A_OMK, 32'h3F);
    chk("R11 all masked", 64'(hostIrq), 64'd0);
    busWrite(A_OMK, 32'h00);
    busWrite(A_OS, 32'h3F);
    busWrite(A_IS, 32'h3F);

    // R9 doorbell
    busWrite(A_DB, 32'h3);
    busWrite(A_DB, 32'h4);
    busRead(A_DB, rd);  chk("R9 doorbell or", 64'(rd), 64'h7);
    chk("R9 lclDoorbell", 64'(lclDoorbell), 64'h7);
    busWrite(A_IS, 32'h04);
    busRead(A_IS, rd);  chk("R10 db live", 64'(rd[2]), 64'd1);
    lclDbClr = 32'h7; @(negedge clk); lclDbClr = '0;
    busRead(A_IS, rd);  chk("R9 db cleared", 64'(rd), 64'd0);
    chk("R11 lclIrq idle", 64'(lclIrq), 64'd0);

    // Random mix against queue models (R2, R7)
    for (int it = 0; it < 400; it++) begin
      case ($urandom % 4)
        0: begin
          h = ($urandom % 2) ? hostHandle({$urandom, 4'h0}) : ({$urandom} & 32'h7FFF_FFE0);
          busWrite(A_INP, h);
          if (mPost.size() < DEPTH) mPost.push_back(h);
        end
        1: if (mPost.size() > 0) begin
          chk("R2 random post", 64'(lclPostHandle), 64'(mPost.pop_front()));
          lclPop();
        end else chk("R2 random empty", 64'(lclPostValid), 64'd0);
        2: begin
          h = $urandom;
          lclPush(h);
          if (mCmpl.size() < DEPTH) mCmpl.push_back(h);
        end
        default: begin
          busRead(A_OUTP, rd);
          if (mCmpl.size() > 0) chk("R7 random cmpl", 64'(rd), 64'(mCmpl.pop_front()));
          else chk("R3 random empty", 64'(rd), 64'hFFFF_FFFF);
        end
      endcase
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule